// File: doc/BRIEF.md
# Three-Phase Gate PWM Generator

This block produces the six gate commands for a three-phase half-bridge power stage. A single 12-bit counter is shared by all three phases. It can count upward, count downward, count up and then down in a triangle, or hold its value. Each phase compares the counter against its own 12-bit duty value to form a raw PWM level. The level is high while the counter is below the duty.

A 3-bit state code per phase chooses what each of the two switches does with that level. A switch can be held off, forced on, driven by the PWM, or, in complementary operation, driven with the high side on the PWM and the low side on its inverse. In complementary operation a selectable dead time delays every rising gate edge, so the two switches of a leg are never on together.

The period and duty inputs are captured into shadow registers only at a counter period boundary, so an update never tears a cycle that is already running. A global enable and a fault-disable input both force every gate low. All control pins are plain levels; there is no streamed data.

Top module: `pwm3_gen`

## Requirements
- R1: While reset is asserted and after it is released with the enable low, all six gate outputs are low.
- R2: With the enable low, all gates are low from the next clock edge on, the counter is held at 0, and period and duty inputs load straight into the shadows.
- R3: Counter mode 1 counts up from 0 to the period and then wraps to 0. A phase in code 6 with duty D (D not above period P) is high for D cycles out of every P+1.
- R4: Counter mode 2 counts down from the period to 0 and then reloads the period. Duty D gives D high cycles out of every P+1.
- R5: Counter mode 0 counts 0 up to P and back down to 1, a period of 2P cycles. Duty D (0 < D ≤ P) gives 2D-1 high cycles per period.
- R6: Counter mode 3 freezes the counter, so the gates stop changing.
- R7: New period and duty values take effect only at a period boundary: the wrap in mode 1, the reload at 0 in mode 2, and the valley in mode 0. A duty change made mid-period leaves the current pulse at its old width.
- R8: Each phase's state code sets its gates as follows. Code 0 holds both off; code 1 forces the low side on; code 2 forces the high side on. Code 5 puts the PWM on the low side with the high side off. Code 6 puts the PWM on the high side with the low side off. Code 7 puts the PWM on the high side and its inverse on the low side. Phase A uses state bits 2:0, B uses 5:3 and C uses 8:6. The duty fields are packed the same way, 12 bits each.
- R9: Codes 3 and 4 hold both switches of that phase off.
- R10: In code 7, each rising gate edge is delayed by dt_sel × DT_STEP cycles (DT_STEP defaults to 25, which is 200 ns at 125 MHz; dt_sel 0 gives no delay). The high and low gates of a phase are never high together.
- R11: Asserting the fault-disable input drives all six gates low at the next clock edge and keeps them low while it stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Generator on when high |
| cnt_mode_i | input | 2 | 0 up/down, 1 up, 2 down, 3 hold |
| period_i | input | 12 | Counter period |
| duty_i | input | 36 | Three 12-bit duty values, phase A in the low bits |
| state_i | input | 9 | Three 3-bit state codes, phase A in the low bits |
| dt_sel_i | input | 3 | Dead-time step count |
| fault_off_i | input | 1 | Forces all gates low |
| gate_hs_o | output | 3 | High-side gates, bit 0 is phase A |
| gate_ls_o | output | 3 | Low-side gates, bit 0 is phase A |

## Verification
The checker enforces some rules on every clock: the two gates of a leg are never high together, a fault or a low enable clears the gates one edge later, hold mode keeps the counter still, reserved codes keep a leg off, and a forced low side comes on. What the checker cannot see, only the bench scenarios can show. These are the pulse widths in each counter direction, the exact dead-time gap, the boundary at which a new duty takes effect, and the full state-code map under a frozen counter.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic [1:0] {
    CM_UPDOWN = 2'd0,
    CM_UP     = 2'd1,
    CM_DOWN   = 2'd2,
    CM_HOLD   = 2'd3
  } cnt_mode_e;

  localparam logic [2:0] ST_OFF    = 3'd0;
  localparam logic [2:0] ST_LS_ON  = 3'd1;
  localparam logic [2:0] ST_HS_ON  = 3'd2;
  localparam logic [2:0] ST_LS_PWM = 3'd5;
  localparam logic [2:0] ST_HS_PWM = 3'd6;
  localparam logic [2:0] ST_COMP   = 3'd7;
endpackage

// File: rtl/pwm3_counter.sv
module pwm3_counter
  import pwm3_pkg::*;
#(
  parameter int CW  = 12,
  parameter int NPH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [CW-1:0]     period_i,
  input  logic [NPH*CW-1:0] duty_i,
  output logic [CW-1:0]     cnt_o,
  output logic [NPH-1:0]    pwm_o
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          up_q, up_n;
  logic          bnd, load;
  logic [CW-1:0] sh_prd;
  logic [CW-1:0] sh_duty [NPH];

  // next-count logic per direction mode; bnd marks the period boundary
  always_comb begin
    cnt_n = cnt_q;
    up_n  = up_q;
    bnd   = 1'b0;
    unique case (cnt_mode_e'(mode_i))
      CM_UP: begin
        if (cnt_q >= sh_prd) begin
          bnd   = 1'b1;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      CM_DOWN: begin
        if (cnt_q == '0) begin
          bnd   = 1'b1;
          cnt_n = period_i;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      CM_UPDOWN: begin
        if (up_q) begin
          if (cnt_q >= sh_prd) begin
            up_n  = 1'b0;
            cnt_n = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end else if (cnt_q == '0) begin
          bnd   = 1'b1;
          up_n  = 1'b1;
          cnt_n = (period_i == '0) ? '0 : CW'(1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      CM_HOLD: cnt_n = cnt_q;
    endcase
    if (!en_i) begin
      cnt_n = '0;
      up_n  = 1'b1;
    end
  end

  assign load = bnd | ~en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      sh_prd <= '0;
    end else begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
      if (load) sh_prd <= period_i;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh_duty[p] <= '0;
      else if (load) sh_duty[p] <= duty_i[p*CW +: CW];
    end
    assign pwm_o[p] = en_i & (cnt_q < sh_duty[p]);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
  import pwm3_pkg::*;
#(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwm_i,
  input  logic           act_i,
  input  logic [2:0]     state_i,
  input  logic [DTW-1:0] dly_i,
  output logic           hs_o,
  output logic           ls_o
);
  logic [1:0]     want, want_q;   // {hs, ls}
  logic [DTW-1:0] dly, tmr_q, tmr_n;

  always_comb begin
    unique case (state_i)
      ST_OFF:    want = 2'b00;
      ST_LS_ON:  want = 2'b01;
      ST_HS_ON:  want = 2'b10;
      ST_LS_PWM: want = {1'b0, pwm_i};
      ST_HS_PWM: want = {pwm_i, 1'b0};
      ST_COMP:   want = {pwm_i, ~pwm_i};
      default:   want = 2'b00;
    endcase
    if (!act_i) want = 2'b00;
  end

  // dead time applies only to the complementary pair
  assign dly = (state_i == ST_COMP) ? dly_i : '0;

  always_comb begin
    if (dly == '0)            tmr_n = '0;
    else if (want != want_q)  tmr_n = dly;
    else if (tmr_q != '0)     tmr_n = tmr_q - 1'b1;
    else                      tmr_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= 2'b00;
      tmr_q  <= '0;
      hs_o   <= 1'b0;
      ls_o   <= 1'b0;
    end else begin
      want_q <= want;
      tmr_q  <= tmr_n;
      hs_o   <= want[1] & (tmr_n == '0);
      ls_o   <= want[0] & (tmr_n == '0);
    end
  end
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int CW      = 12,
  parameter int NPH     = 3,
  parameter int DT_STEP = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [1:0]        cnt_mode_i,
  input  logic [CW-1:0]     period_i,
  input  logic [NPH*CW-1:0] duty_i,
  input  logic [NPH*3-1:0]  state_i,
  input  logic [2:0]        dt_sel_i,
  input  logic              fault_off_i,
  output logic [NPH-1:0]    gate_hs_o,
  output logic [NPH-1:0]    gate_ls_o
);
  localparam int DT_MAX = 7 * DT_STEP;
  localparam int DTW    = $clog2(DT_MAX + 1);

  logic [CW-1:0]  cnt_w;
  logic [NPH-1:0] pwm_w;
  logic [DTW-1:0] dly_w;
  logic           act_w;

  assign dly_w = DTW'(32'(dt_sel_i) * DT_STEP);
  assign act_w = enable_i & ~fault_off_i;

  pwm3_counter #(.CW(CW), .NPH(NPH)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (enable_i),
    .mode_i   (cnt_mode_i),
    .period_i (period_i),
    .duty_i   (duty_i),
    .cnt_o    (cnt_w),
    .pwm_o    (pwm_w)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pwm3_phase #(.DTW(DTW)) u_ph (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwm_i   (pwm_w[p]),
      .act_i   (act_w),
      .state_i (state_i[p*3 +: 3]),
      .dly_i   (dly_w),
      .hs_o    (gate_hs_o[p]),
      .ls_o    (gate_ls_o[p])
    );
  end
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
  parameter int CW  = 12,
  parameter int NPH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable_i,
  input logic             fault_off_i,
  input logic [1:0]       cnt_mode_i,
  input logic [NPH*3-1:0] state_i,
  input logic [NPH-1:0]   gate_hs_o,
  input logic [NPH-1:0]   gate_ls_o,
  input logic [CW-1:0]    cnt
);
  // R10
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hs_o & gate_ls_o) == '0);

  // R11
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_off_i |=> (gate_hs_o == '0) && (gate_ls_o == '0));

  // R2
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (gate_hs_o == '0) && (gate_ls_o == '0) && (cnt == '0));

  // R6
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && cnt_mode_i == 2'd3) |=> $stable(cnt));

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    // R9
    reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i[p*3 +: 3] == 3'd3 || state_i[p*3 +: 3] == 3'd4)
      |=> !gate_hs_o[p] && !gate_ls_o[p]);

    // R8
    forced_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i[p*3 +: 3] == 3'd1 && enable_i && !fault_off_i)
      |=> gate_ls_o[p] && !gate_hs_o[p]);
  end
endmodule

bind pwm3_gen pwm3_chk #(.CW(CW), .NPH(NPH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .fault_off_i (fault_off_i),
  .cnt_mode_i  (cnt_mode_i),
  .state_i     (state_i),
  .gate_hs_o   (gate_hs_o),
  .gate_ls_o   (gate_ls_o),
  .cnt         (cnt_w)
);

// File: tb/pwm3_gen_tb.sv
module pwm3_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic [1:0]  cnt_mode_i = 2'd0;
  logic [11:0] period_i = '0;
  logic [35:0] duty_i = '0;
  logic [8:0]  state_i = 9'o777;
  logic [2:0]  dt_sel_i = '0;
  logic        fault_off_i = 1'b0;
  logic [2:0]  gate_hs_o, gate_ls_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm3_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .cnt_mode_i(cnt_mode_i),
    .period_i(period_i), .duty_i(duty_i), .state_i(state_i), .dt_sel_i(dt_sel_i),
    .fault_off_i(fault_off_i), .gate_hs_o(gate_hs_o), .gate_ls_o(gate_ls_o)
  );

  // {state[2:0], duty[11:0], exp_hs, exp_ls} for phase A under a frozen counter at 0
  localparam logic [16:0] VEC [0:10] = '{
    {3'd0, 12'd5, 1'b0, 1'b0},
    {3'd1, 12'd5, 1'b0, 1'b1},
    {3'd2, 12'd5, 1'b1, 1'b0},
    {3'd3, 12'd5, 1'b0, 1'b0},
    {3'd4, 12'd5, 1'b0, 1'b0},
    {3'd5, 12'd5, 1'b0, 1'b1},
    {3'd5, 12'd0, 1'b0, 1'b0},
    {3'd6, 12'd5, 1'b1, 1'b0},
    {3'd6, 12'd0, 1'b0, 1'b0},
    {3'd7, 12'd5, 1'b1, 1'b0},
    {3'd7, 12'd0, 1'b0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n, output int nh, output int nl,
                         output int nboth, output int nnone);
    nh = 0; nl = 0; nboth = 0; nnone = 0;
    repeat (n) begin
      @(negedge clk);
      if (gate_hs_o[0]) nh++;
      if (gate_ls_o[0]) nl++;
      if (gate_hs_o[0] && gate_ls_o[0]) nboth++;
      if (!gate_hs_o[0] && !gate_ls_o[0]) nnone++;
    end
  endtask

  task automatic setup_a(input logic [1:0] mode, input int prd, input int duty,
                         input logic [2:0] st, input logic [2:0] dt);
    enable_i = 1'b0;
    step(1);
    cnt_mode_i = mode;
    period_i = 12'(prd);
    duty_i[11:0] = 12'(duty);
    state_i[2:0] = st;
    dt_sel_i = dt;
    step(2);
    enable_i = 1'b1;
  endtask

  task automatic run_len(output int n);
    n = 1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (gate_hs_o[0]) n++;
      else break;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = gate_hs_o[0];
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!prev && gate_hs_o[0]) break;
      prev = gate_hs_o[0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nh, nl, nb, nn, r1, r2, diffs;
    logic hs0, ls0;

    // R1 reset state
    step(2);
    check("R1 hs in reset", int'(gate_hs_o), 0);
    check("R1 ls in reset", int'(gate_ls_o), 0);
    rst_n = 1'b1;
    step(4);
    check("R1 hs after reset", int'(gate_hs_o), 0);
    check("R1 ls after reset", int'(gate_ls_o), 0);

    // R8 / R9 state-code table, counter frozen at 0
    state_i[8:3] = {3'd2, 3'd1};
    for (int i = 0; i < 11; i++) begin
      setup_a(2'd3, 20, int'(VEC[i][13:2]), VEC[i][16:14], 3'd0);
      step(3);
      check($sformatf("R8/R9 code %0d duty %0d hs", VEC[i][16:14], VEC[i][13:2]),
            int'(gate_hs_o[0]), int'(VEC[i][1]));
      check($sformatf("R8/R9 code %0d duty %0d ls", VEC[i][16:14], VEC[i][13:2]),
            int'(gate_ls_o[0]), int'(VEC[i][0]));
    end
    check("R8 phases B,C hs", int'(gate_hs_o[2:1]), 2);
    check("R8 phases B,C ls", int'(gate_ls_o[2:1]), 1);
    state_i[8:3] = '0;

    // R3 up mode
    setup_a(2'd1, 9, 4, 3'd6, 3'd0);
    step(20);
    measure(100, nh, nl, nb, nn);
    check("R3 up high cycles", nh, 40);
    check("R8 code 6 low side", nl, 0);

    // R4 down mode
    setup_a(2'd2, 9, 4, 3'd6, 3'd0);
    step(20);
    measure(100, nh, nl, nb, nn);
    check("R4 down high cycles", nh, 40);

    // R5 up/down mode
    setup_a(2'd0, 9, 4, 3'd6, 3'd0);
    step(20);
    measure(180, nh, nl, nb, nn);
    check("R5 updown high cycles", nh, 70);

    // R6 hold freezes the gates
    cnt_mode_i = 2'd3;
    step(2);
    hs0 = gate_hs_o[0];
    ls0 = gate_ls_o[0];
    diffs = 0;
    repeat (50) begin
      @(negedge clk);
      if (gate_hs_o[0] != hs0 || gate_ls_o[0] != ls0) diffs++;
    end
    check("R6 hold gate changes", diffs, 0);

    // R7 duty change applied only at the period boundary
    setup_a(2'd1, 19, 4, 3'd6, 3'd0);
    step(30);
    wait_rise();
    duty_i[11:0] = 12'd8;
    run_len(r1);
    wait_rise();
    run_len(r2);
    check("R7 pulse in current period", r1, 4);
    check("R7 pulse after boundary", r2, 8);

    // R10 dead time, 2 steps = 50 cycles, period 200, duty 100
    setup_a(2'd1, 199, 100, 3'd7, 3'd2);
    step(250);
    measure(2000, nh, nl, nb, nn);
    check("R10 dt2 high side", nh, 500);
    check("R10 dt2 low side", nl, 500);
    check("R10 dt2 overlap", nb, 0);
    check("R10 dt2 both off", nn, 1000);
    dt_sel_i = 3'd1;
    step(250);
    measure(2000, nh, nl, nb, nn);
    check("R10 dt1 high side", nh, 750);
    check("R10 dt1 low side", nl, 750);
    dt_sel_i = 3'd0;
    step(250);
    measure(2000, nh, nl, nb, nn);
    check("R10 dt0 high side", nh, 1000);
    check("R10 dt0 both off", nn, 0);

    // R11 fault forces gates off
    fault_off_i = 1'b1;
    step(1);
    check("R11 hs on fault", int'(gate_hs_o), 0);
    check("R11 ls on fault", int'(gate_ls_o), 0);
    measure(20, nh, nl, nb, nn);
    check("R11 gates during fault", nh + nl, 0);
    fault_off_i = 1'b0;
    step(3);
    check("R11 recovery one gate on", int'(gate_hs_o[0] ^ gate_ls_o[0]), 1);

    // R2 disable
    enable_i = 1'b0;
    step(1);
    check("R2 hs disabled", int'(gate_hs_o), 0);
    check("R2 ls disabled", int'(gate_ls_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule